// File: doc/BRIEF.md
# Suffix Pre-Hash Filter

This block sits beside an automaton-based string matcher and decides, for a non-root automaton state, whether the costly bitmap transition step can be skipped. Each state owns a 32-bit hint vector made of one 16-bit sub-vector per suffix length (1 and 2). When the controller raises `start`, the block takes the next two text bytes and hashes each one. The hash keeps the low nibble of the byte and expands it to a 16-bit one-hot word. Each hashed word is tested against the matching sub-vector of the current state.

The tests are chained from the shortest length upward. A miss at length 1 ends the decision as a non-hit. A hit is reported only when every length passes. A non-hit tells the controller to return straight to the root state. A hit may be a false positive, and the slow path then resolves it. The answer appears one cycle after `start`, together with a one-cycle `done` pulse.

A host write port loads the hint vectors into an internal table indexed by state number. The vectors themselves are computed elsewhere.

Top module: `suffix_prehash_gate`

## Requirements
- R1: While reset is asserted, and immediately after it is released, `done` and `hit` are 0.
- R2: A cycle with `start` high produces `done` high in exactly the following cycle. `done` is low in every other cycle. Back-to-back starts give back-to-back `done` pulses.
- R3: The length-1 test uses bits [3:0] of `text_pair[7:0]` (the first byte) as an index n. It passes when bit n of the state's vector is 1.
- R4: The length-2 test uses bits [11:8] of `text_pair` (the second byte's low nibble) as an index m. It passes when bit 16+m of the state's vector is 1.
- R5: `hit` is 1 only when both the length-1 and the length-2 tests pass. When the length-1 test misses, the result is a non-hit whatever bits [31:16] hold.
- R6: With `wr_en` high, `wr_vec` is stored at entry `wr_state`, and tests that start in later cycles use it. Writing one state leaves every other state's vector unchanged.
- R7: When a write and a start address the same state in the same cycle, that test uses the vector held before the write.
- R8: `hit` keeps its last value in cycles without `done`, whatever the other inputs do.
- R9: The upper nibbles `text_pair[7:4]` and `text_pair[15:12]` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the hint table |
| wr_state | input | STATE_W (6) | State number to write |
| wr_vec | input | 32 | Hint vector to store; [15:0] is length 1, [31:16] is length 2 |
| start | input | 1 | Begin a test for `cur_state` and `text_pair` |
| cur_state | input | STATE_W (6) | Current automaton state |
| text_pair | input | 16 | Next two text bytes; the first byte is in [7:0] |
| done | output | 1 | One-cycle pulse in the cycle after `start` |
| hit | output | 1 | 1 = run the slow automaton step; 0 = go to the root state |

## Verification
A corrupted table entry, or a wrong hash bit position, shows up on `hit` in the `done` cycle of the first test that reads the affected state and nibble. Random vectors and text pairs are spread over all states so that such faults surface quickly. A broken chain or AND shows as a hit when one sub-vector is empty. A read-during-write ordering fault flips the result of the collision test in its own `done` cycle. A stray register update is caught by `hit` changing, or `done` rising, in an idle cycle.

// File: rtl/prehash_pkg.sv
package prehash_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int HASH_W = 1 << NIB_W;
endpackage

// File: rtl/prehash_vec_mem.sv
module prehash_vec_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // Read is combinational, so a same-cycle write is seen one cycle later
  assign rd_data = mem[rd_addr];

  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/prehash_onehot.sv
module prehash_onehot
  import prehash_pkg::*;
(
  input  logic [NIB_W-1:0]  nib,
  output logic [HASH_W-1:0] hot
);
  always_comb begin
    hot = '0;
    hot[nib] = 1'b1;
  end
endmodule

// File: rtl/prehash_chain.sv
module prehash_chain
  import prehash_pkg::*;
#(
  parameter int MAX_LEN = 2
) (
  input  logic [MAX_LEN*HASH_W-1:0] vec,
  input  logic [MAX_LEN*HASH_W-1:0] hot,
  output logic                      pass_all
);
  logic [MAX_LEN-1:0] test;
  logic [MAX_LEN-1:0] pass;

  for (genvar j = 0; j < MAX_LEN; j++) begin : g_len
    assign test[j] = |(hot[j*HASH_W +: HASH_W] & vec[j*HASH_W +: HASH_W]);
    if (j == 0) begin : g_first
      assign pass[j] = test[j];
    end else begin : g_next
      // A longer prefix only counts when every shorter one passed
      assign pass[j] = pass[j-1] & test[j];
    end
  end

  assign pass_all = pass[MAX_LEN-1];
endmodule

// File: rtl/suffix_prehash_gate.sv
module suffix_prehash_gate
  import prehash_pkg::*;
#(
  parameter int STATE_W = 6,
  parameter int MAX_LEN = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [STATE_W-1:0]          wr_state,
  input  logic [MAX_LEN*HASH_W-1:0]   wr_vec,
  input  logic                        start,
  input  logic [STATE_W-1:0]          cur_state,
  input  logic [MAX_LEN*BYTE_W-1:0]   text_pair,
  output logic                        done,
  output logic                        hit
);
  localparam int VEC_W = MAX_LEN * HASH_W;

  logic [VEC_W-1:0] state_vec;
  logic [VEC_W-1:0] hot_all;
  logic             chain_hit;
  logic             done_d, hit_d;
  logic             done_q, hit_q;
  logic [MAX_LEN*(BYTE_W-NIB_W)-1:0] unused_hi_nibbles;

  prehash_vec_mem #(.ADDR_W(STATE_W), .DATA_W(VEC_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_state),
    .wr_data (wr_vec),
    .rd_addr (cur_state),
    .rd_data (state_vec)
  );

  for (genvar j = 0; j < MAX_LEN; j++) begin : g_hash
    prehash_onehot u_hot (
      .nib (text_pair[j*BYTE_W +: NIB_W]),
      .hot (hot_all[j*HASH_W +: HASH_W])
    );
    assign unused_hi_nibbles[j*(BYTE_W-NIB_W) +: (BYTE_W-NIB_W)] =
      text_pair[j*BYTE_W+NIB_W +: (BYTE_W-NIB_W)];
  end

  prehash_chain #(.MAX_LEN(MAX_LEN)) u_chain (
    .vec      (state_vec),
    .hot      (hot_all),
    .pass_all (chain_hit)
  );

  always_comb begin
    done_d = start;
    hit_d  = hit_q;
    if (start) begin
      hit_d = chain_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      hit_q  <= hit_d;
    end
  end

  assign done = done_q;
  assign hit  = hit_q;

  p_done_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  p_done_only_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  p_hit_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(hit));
  p_hash_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ($countones(hot_all[HASH_W-1:0]) == 1));
  p_hash_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ($countones(hot_all[VEC_W-1:HASH_W]) == 1));
endmodule

// File: tb/suffix_prehash_gate_bench.sv
module suffix_prehash_gate_bench;
  localparam int NST = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [5:0]  wr_state;
  logic [31:0] wr_vec;
  logic        start;
  logic [5:0]  cur_state;
  logic [15:0] text_pair;
  logic        done, hit;

  int checks = 0;
  int failures = 0;
  logic [31:0] model [NST];

  always #4 clk = ~clk;

  suffix_prehash_gate u_suffix_prehash_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_state(wr_state),
    .wr_vec(wr_vec), .start(start), .cur_state(cur_state),
    .text_pair(text_pair), .done(done), .hit(hit)
  );

  function automatic logic exp_hit(logic [31:0] v, logic [15:0] t);
    return v[t[3:0]] && v[16 + t[11:8]];
  endfunction

  task automatic chk(logic ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [5:0] s, logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_state = s; wr_vec = v;
    @(negedge clk);
    wr_en = 1'b0;
    model[s] = v;
  endtask

  task automatic do_test(logic [5:0] s, logic [15:0] t, string req);
    logic e;
    e = exp_hit(model[s], t);
    @(negedge clk);
    start = 1'b1; cur_state = s; text_pair = t;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, {req, " R2 done"}, 32'(done), 32'd1);
    chk(hit == e, req, 32'(hit), 32'(e));
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog R2 actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] t;
    logic        e1, e2;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 1'b0; wr_state = '0; wr_vec = '0;
    start = 1'b0; cur_state = '0; text_pair = '0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && hit == 1'b0, "R1 in reset", {30'd0, done, hit}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && hit == 1'b0, "R1 after release", {30'd0, done, hit}, 32'd0);

    for (int s = 0; s < NST; s++) do_write(6'(s), $urandom());

    // R3/R4 directed: single bits at each length
    do_write(6'd1, 32'h0001_0008);
    do_test(6'd1, 16'h0003, "R3 len1 bit3 len2 bit0");
    do_test(6'd1, 16'h0002, "R3 len1 miss");
    do_test(6'd1, 16'h0103, "R4 len2 miss");
    do_write(6'd2, 32'h8000_0001);
    do_test(6'd2, 16'h0F00, "R4 len2 bit31");
    // R5: empty length-1 sub-vector, full length-2
    do_write(6'd3, 32'hFFFF_0000);
    for (int n = 0; n < 16; n++) do_test(6'd3, {8'h00, 4'h0, 4'(n)}, "R5 short miss");
    do_write(6'd4, 32'h0000_FFFF);
    do_test(6'd4, 16'h0505, "R5 len2 empty");
    do_write(6'd5, 32'hFFFF_FFFF);
    do_test(6'd5, 16'h0A07, "R5 all set");
    // R9: upper nibbles ignored
    do_test(6'd1, 16'hF0A3, "R9 high nibbles");
    do_test(6'd1, 16'h5F63, "R9 high nibbles");

    // R6: neighbours unaffected by a write
    do_write(6'd10, 32'hFFFF_FFFF);
    do_write(6'd11, 32'h0000_0000);
    do_test(6'd10, 16'h0C0C, "R6 neighbour kept");
    do_test(6'd11, 16'h0C0C, "R6 written zero");

    // R7: write and start to the same state in one cycle
    do_write(6'd20, 32'h0002_0001);
    @(negedge clk);
    wr_en = 1'b1; wr_state = 6'd20; wr_vec = 32'h0000_0000;
    start = 1'b1; cur_state = 6'd20; text_pair = 16'h0100;
    @(negedge clk);
    wr_en = 1'b0; start = 1'b0;
    chk(hit == 1'b1, "R7 old vector used", 32'(hit), 32'd1);
    model[20] = 32'h0;
    do_test(6'd20, 16'h0100, "R7 new vector after");

    // R2 back-to-back with a zero-to-one transition, then idle
    @(negedge clk);
    start = 1'b1; cur_state = 6'd5; text_pair = 16'h0000;
    @(negedge clk);
    chk(done && hit, "R2 b2b first", {30'd0, done, hit}, 32'd3);
    cur_state = 6'd11;
    @(negedge clk);
    start = 1'b0;
    chk(done && !hit, "R2 b2b second", {30'd0, done, hit}, 32'd2);
    @(negedge clk);
    chk(done == 1'b0, "R2 pulse ends", 32'(done), 32'd0);

    // R8: hit held across idle cycles with moving inputs and writes
    do_test(6'd5, 16'h0000, "R8 setup");
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cur_state = 6'($urandom()); text_pair = 16'($urandom());
      wr_en = 1'b1; wr_state = 6'd5; wr_vec = 32'h0;
      @(negedge clk);
      wr_en = 1'b0;
      chk(hit == 1'b1 && done == 1'b0, "R8 hold", {30'd0, done, hit}, 32'd1);
    end
    model[5] = 32'h0;

    // Random mix of writes and tests
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 4) == 0) begin
        do_write(6'($urandom()), $urandom() & $urandom());
      end else begin
        t = 16'($urandom());
        do_test(6'($urandom()), t, "R3 R4 R5 random");
      end
    end

    // Pairs where both single tests are checked for consistency
    for (int i = 0; i < 200; i++) begin
      t = 16'($urandom());
      e1 = exp_hit(model[i % NST], t);
      e2 = exp_hit(model[i % NST], t ^ 16'hF0F0);
      chk(e1 == e2, "R9 model", 32'(e1), 32'(e2));
      do_test(6'(i % NST), t ^ 16'hF0F0, "R9 random high nibbles");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule